// File: doc/BRIEF.md
# Fan PWM Duty Register with Deferred Software Value

This block holds the 8-bit duty code for a fan PWM output and produces the waveform from it. Two sources can supply the duty. When the software-control mode input is high, the value comes from the register write port. When it is low, an automatic-control input supplies it. A write made while software control is off does not reach the output. It lands in a holding register, and that held value is moved into service when the mode input rises. The read port always shows the duty code that is producing the waveform at that moment, not the last code written.

The waveform period is 255 prescaled ticks. A new duty value is picked up only where a period begins, so no runt pulse or stretched pulse can appear. Each duty step is 1/255 of the period. The reset input is asynchronous and active low. Inside the block, reset is released through a two-flop synchronizer, so internal state leaves reset two clock edges after `rst_n` rises.

Top module: `fan_duty_pwm`

## Requirements
- R1: After reset, the read port shows 0x55. The holding register also starts at 0x55, so entering software mode with no write made gives a duty of 0x55.
- R2: Duty code 0x00 keeps `pwm_out` low for the whole period.
- R3: Duty code 0xFF keeps `pwm_out` high for the whole period.
- R4: The period is 255 ticks, and one tick is PRESCALE clocks. Over any full period at a constant code N, `pwm_out` is high for N*PRESCALE clocks, starting at the first tick of the period.
- R5: `rd_data` always equals the duty code currently producing `pwm_out`, in every mode.
- R6: A write while `sw_mode` is 1 becomes the requested duty on the next clock and drives the output from the next period start.
- R7: While `sw_mode` is 0, the requested duty follows `auto_duty`, and a write has no effect on `pwm_out` or `rd_data`.
- R8: On a rising edge of `sw_mode` with no write in that cycle, the held value becomes the requested duty.
- R9: The active duty changes only at the start of a period, when the period counter wraps to 0.
- R10: A write in software mode also updates the holding register. Leaving software mode and entering it again, with no write in between, restores that value.
- R11: If a write arrives in the same cycle that `sw_mode` rises, the written value wins over the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Duty code to write |
| rd_data | output | 8 | Duty code currently producing the waveform |
| sw_mode | input | 1 | 1 = software duty control active |
| auto_duty | input | 8 | Duty code from the automatic control logic |
| pwm_out | output | 1 | PWM waveform |

## Verification
The in-RTL assertions check these behaviours on every cycle:
- how the requested duty is chosen among a software write, a rise of the mode input and the automatic input;
- that the active duty changes only where the period counter wraps;
- that the counter stays in range;
- that codes 0x00 and 0xFF pin the output low and high.

Some properties cover a whole period or a sequence of mode changes, and only the bench scenarios can show them:
- the exact high time for a mid-range code;
- that a write made outside software mode is held back and surfaces only at the next rise of the mode input;
- that a software-mode write survives a round trip out of and back into software mode;
- that a write wins over the held value when the two coincide.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int DUTY_W = 8;
  localparam int STEPS = (1 << DUTY_W) - 1;          // 255 ticks per period
  localparam logic [DUTY_W-1:0] LAST_STEP = DUTY_W'(STEPS - 1);
  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/fdp_duty_regs.sv
module fdp_duty_regs
  import fdp_pkg::*;
#(
  parameter duty_t RESET_DUTY = 8'h55
) (
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  wr_en,
  input  duty_t wr_data,
  input  logic  sw_mode,
  input  duty_t auto_duty,
  output duty_t target_o
);
  duty_t hold_q, hold_d;
  duty_t target_q, target_d;
  logic  sw_q;
  logic  sw_rise;

  assign sw_rise = sw_mode & ~sw_q;

  always_comb begin
    hold_d   = hold_q;
    target_d = target_q;
    if (wr_en) hold_d = wr_data;
    if (!sw_mode)     target_d = auto_duty;
    else if (wr_en)   target_d = wr_data;
    else if (sw_rise) target_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= RESET_DUTY;
      target_q <= RESET_DUTY;
      sw_q     <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      target_q <= target_d;
      sw_q     <= sw_mode;
    end
  end

  assign target_o = target_q;

  AST_AUTO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !sw_mode |=> target_o == $past(auto_duty)); // R7
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (sw_mode && wr_en) |=> target_o == $past(wr_data)); // R6
  AST_RISE_XFER: assert property (@(posedge clk) disable iff (!rst_ni)
    (sw_mode && !sw_q && !wr_en) |=> target_o == $past(hold_q)); // R8
  AST_SW_STEADY: assert property (@(posedge clk) disable iff (!rst_ni)
    (sw_mode && sw_q && !wr_en) |=> $stable(target_o)); // R10
endmodule

// File: rtl/fdp_tick_gen.sv
module fdp_tick_gen #(
  parameter int PRESCALE = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pcnt_q, pcnt_d;

      always_comb begin
        if (pcnt_q == PLAST) pcnt_d = '0;
        else                 pcnt_d = pcnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) pcnt_q <= '0;
        else         pcnt_q <= pcnt_d;
      end

      assign tick_o = (pcnt_q == PLAST);

      AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
        pcnt_q <= PLAST); // R4
    end
  endgenerate
endmodule

// File: rtl/fdp_pwm_core.sv
module fdp_pwm_core
  import fdp_pkg::*;
#(
  parameter duty_t RESET_DUTY = 8'h55
) (
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  tick,
  input  duty_t target,
  output duty_t active_o,
  output logic  pwm_o
);
  duty_t step_q, step_d;
  duty_t act_q, act_d;
  logic  pwm_q, pwm_d;
  logic  wrap;

  assign wrap = tick && (step_q == LAST_STEP);

  always_comb begin
    step_d = step_q;
    act_d  = act_q;
    if (tick) step_d = wrap ? '0 : step_q + 1'b1;
    if (wrap) act_d = target;
    pwm_d = (step_d < act_d);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      act_q  <= RESET_DUTY;
      pwm_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      act_q  <= act_d;
      pwm_q  <= pwm_d;
    end
  end

  assign active_o = act_q;
  assign pwm_o    = pwm_q;

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    step_q <= LAST_STEP); // R4
  AST_MIDPERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(act_q) |-> step_q == '0); // R9
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (act_q == '0 && $past(rst_ni)) |-> !pwm_q); // R2
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (act_q == '1 && $past(act_q) == '1 && $past(rst_ni)) |-> pwm_q); // R3
endmodule

// File: rtl/fan_duty_pwm.sv
module fan_duty_pwm
  import fdp_pkg::*;
#(
  parameter int    PRESCALE   = 2,
  parameter duty_t RESET_DUTY = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DUTY_W-1:0] wr_data,
  output logic [DUTY_W-1:0] rd_data,
  input  logic              sw_mode,
  input  logic [DUTY_W-1:0] auto_duty,
  output logic              pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       tick;
  duty_t      target;
  duty_t      active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fdp_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_ni(rst_ni), .tick_o(tick)
  );

  fdp_duty_regs #(.RESET_DUTY(RESET_DUTY)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_data(wr_data),
    .sw_mode(sw_mode), .auto_duty(auto_duty), .target_o(target)
  );

  fdp_pwm_core #(.RESET_DUTY(RESET_DUTY)) u_core (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .target(target),
    .active_o(active), .pwm_o(pwm_out)
  );

  assign rd_data = active;

  AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    $changed(rd_data) |-> $past(target) == rd_data); // R5
endmodule

// File: tb/tb_fan_duty_pwm.sv
`timescale 1ns/1ps
module tb_fan_duty_pwm;
  localparam int P = 2;
  localparam int PERIOD = 255 * P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sw_mode = 1'b0;
  logic [7:0] auto_duty = '0;
  logic [7:0] rd_data;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fan_duty_pwm #(.PRESCALE(P), .RESET_DUTY(8'h55)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sw_mode(sw_mode), .auto_duty(auto_duty),
    .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_r1 = 0, m_r2 = 0;
  int m_pre = 0, m_step = 0, m_act = 'h55, m_req = 'h55, m_hold = 'h55;
  int m_swq = 0;
  bit m_pwm = 0;

  always @(posedge clk) begin
    int i_wr, i_wd, i_sw, i_auto;
    bit tk;
    i_wr = wr_en; i_wd = wr_data; i_sw = sw_mode; i_auto = auto_duty;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
    end
    if (m_r2 == 0) begin
      m_pre = 0; m_step = 0; m_act = 'h55; m_req = 'h55; m_hold = 'h55;
      m_swq = 0; m_pwm = 0;
    end else begin
      tk = (m_pre == P - 1);
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) begin
        if (m_step == 254) begin
          m_step = 0;
          m_act = m_req;
        end else m_step = m_step + 1;
      end
      m_pwm = (m_step < m_act);
      if (!i_sw)                 m_req = i_auto;
      else if (i_wr)             m_req = i_wd;
      else if (m_swq == 0)       m_req = m_hold;
      if (i_wr) m_hold = i_wd;
      m_swq = i_sw;
    end
    if (rst_n) begin
      m_r2 = m_r1; m_r1 = 1;
    end
    #1;
    if (!done) begin
      checks++;
      if (rd_data !== m_act[7:0]) begin
        errors++;
        $display("FAIL R5 rd_data actual %02h expected %02h at %0t", rd_data, m_act[7:0], $time);
      end
      checks++;
      if (pwm_out !== m_pwm) begin
        errors++;
        $display("FAIL R4 pwm_out actual %0b expected %0b at %0t", pwm_out, m_pwm, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_periods(input int n);
    repeat (n * PERIOD + 4) @(negedge clk);
  endtask

  task automatic count_high(output int hi);
    hi = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset duty", rd_data, 'h55);

    // automatic mode, code zero
    auto_duty = 8'h00;
    wait_periods(2);
    check("R7 auto follow", rd_data, 0);
    count_high(hi);
    check("R2 zero never high", hi, 0);

    auto_duty = 8'hFF;
    wait_periods(2);
    count_high(hi);
    check("R3 full always high", hi, PERIOD);

    // hidden write outside software mode
    auto_duty = 8'h40;
    write(8'h90);
    wait_periods(2);
    check("R7 write ignored outside sw", rd_data, 'h40);
    count_high(hi);
    check("R4 high time 0x40", hi, 'h40 * P);

    // mode rises: held value takes over
    @(negedge clk); sw_mode = 1'b1;
    wait_periods(2);
    check("R8 held value on rise", rd_data, 'h90);

    write(8'h10);
    wait_periods(2);
    check("R6 sw write", rd_data, 'h10);
    count_high(hi);
    check("R4 high time 0x10", hi, 'h10 * P);

    // round trip out of software mode
    @(negedge clk); sw_mode = 1'b0; auto_duty = 8'h33;
    wait_periods(2);
    check("R5 read shows auto", rd_data, 'h33);
    @(negedge clk); sw_mode = 1'b1;
    wait_periods(2);
    check("R10 sw write kept in hold", rd_data, 'h10);

    // write coincides with mode rise
    @(negedge clk); sw_mode = 1'b0;
    write(8'hA0);
    @(negedge clk); sw_mode = 1'b1; wr_en = 1'b1; wr_data = 8'hC5;
    @(negedge clk); wr_en = 1'b0;
    wait_periods(2);
    check("R11 write wins on rise", rd_data, 'hC5);

    // reset restores hold value
    @(negedge clk); sw_mode = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset after run", rd_data, 'h55);
    @(negedge clk); sw_mode = 1'b1;
    wait_periods(2);
    check("R1 hold resets to 0x55", rd_data, 'h55);
    count_high(hi);
    check("R4 high time 0x55", hi, 'h55 * P);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule